// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Controller

This block is a supervision timer that counts down from a programmed tick count. It advances only on cycles where the `tick_en` input is high, and only while the halt bit is clear. Software keeps it quiet by writing the kick register before the count runs out. When the count does run out, the block sets a timeout flag, raises `irq` if that is enabled, and reloads itself automatically. If the flag is still set when the next period ends, the block records a second-timeout flag and pulses `sys_rst_req` for one cycle. A no-reboot gate suppresses that pulse, and a lock input can force the gate on.

The second-timeout flag and a boot flag live in a power-on domain (`por_n`). They therefore survive the system reset that the block itself requests. All other state is reset by either `rst_n` or `por_n`.

The sequencing is a three-state machine:
- `S_HALT`: counting is stopped by the halt bit. It moves to `S_RUN` when the halt bit clears, or straight to `S_FIRE` if a second expiry lands in that same cycle.
- `S_RUN`: counting. It moves to `S_FIRE` on an expiry that finds the timeout flag set while the gate is open. It moves to `S_HALT` when the halt bit is set.
- `S_FIRE`: a single cycle that drives `sys_rst_req`. It then returns to `S_RUN`, or to `S_HALT` if the halt bit is set.

Register map (`reg_addr`):

| Address | Register | Contents |
|---|---|---|
| 0 | control | halt bit at bit 11, general bit at bit 9 |
| 1 | timeout | tick count in bits [9:0] |
| 2 | kick | writing reloads the count |
| 3 | status 1 | timeout flag at bit 0 |
| 4 | status 2 | second-timeout flag at bit 0, boot flag at bit 1 |
| 5 | interrupt enable | enable at bit 0 |
| 6 | gate | no-reboot at bit 0 |

Reads are combinational from `reg_addr`.

Top module: `wdog_ctrl`

## Requirements
- R1: After power-on reset:
  - control reads 0x0800 (halted);
  - timeout reads 16;
  - status 1 reads 0;
  - status 2 reads 0x2 (only the boot flag is set);
  - interrupt enable and gate read 0;
  - `irq` and `sys_rst_req` are low.
- R2: The count does not advance while the halt bit (control bit 11) is 1, or while `tick_en` is 0. Clearing the halt bit resumes counting from the held value.
- R3: Control stores only bit 11 and bit 9. Every other bit reads 0 regardless of what was written.
- R4: A write to timeout stores the value clamped to the range [2, 1023]. Out-of-range values saturate to the nearer limit and do not wrap.
- R5: A write to kick with any of bits [4:0] set reloads the count with the timeout value. A kick write whose bits [4:0] are all 0 has no effect.
- R6: A new timeout value does not change the running count. It is used only from the next reload, whether that reload comes from a kick or from an expiry.
- R7: With a timeout value of T, an expiry occurs on the T-th counted tick after a reload. The expiry sets status 1 bit 0. `irq` equals status 1 bit 0 ANDed with interrupt-enable bit 0.
- R8: A write of 1 to a status bit clears it. A write of 0 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R9: An expiry that finds status 1 bit 0 already set does three things:
  - it sets status 2 bit 0;
  - it raises `sys_rst_req` in the following cycle;
  - it keeps `sys_rst_req` high for exactly one cycle.
- R10: While gate bit 0 is 1, `sys_rst_req` stays low, but a second expiry still sets status 2 bit 0. While `nr_lock` is 1, gate bit 0 reads 1 even after a write of 0.
- R11: Status 2 bits 0 and 1 keep their values across `rst_n`. Only `por_n` resets them.
- R12: A single write of 0x3 to status 2 clears only bit 0. Bit 1 is cleared by a write that has bit 1 set and bit 0 clear.
- R13: A kick write in the same cycle as an expiry reloads the count, and that expiry does not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| por_n | input | 1 | power-on reset, active low, clears the persistent flags |
| rst_n | input | 1 | system reset, active low |
| tick_en | input | 1 | one-cycle tick qualifier for the countdown |
| nr_lock | input | 1 | forces the no-reboot gate on |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 3 | register address |
| reg_wdata | input | DW | write data |
| reg_rdata | output | DW | read data for `reg_addr` |
| irq | output | 1 | first-expiry interrupt request |
| sys_rst_req | output | 1 | one-cycle system reset request |

## Verification
A wrong count or reload value shows up as a wrong cycle count between a kick and the rise of `irq` or of status 1 bit 0. That error is visible within one timeout period. A wrong state in the sequencer shows up as a `sys_rst_req` pulse that is missing, too long, or present despite the gate. It appears at the second expiry, one period after the first. Corruption of the power-on flags is seen at the first read of status 2 after a system reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned HALT_BIT = 11;
    localparam int unsigned KEEP_BIT = 9;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TOVAL = 3'd1;
    localparam logic [ADDR_W-1:0] A_KICK  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STS1  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STS2  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IRQEN = 3'd5;
    localparam logic [ADDR_W-1:0] A_GATE  = 3'd6;

    typedef enum logic [1:0] {
        S_HALT = 2'd0,
        S_RUN  = 2'd1,
        S_FIRE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned     TW      = 10,
    parameter logic [TW-1:0]   RST_VAL = 10'd16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          reload,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] count,
    output logic          expire
);
    localparam logic [TW-1:0] LAST = TW'(1);

    // a kick in the expiry cycle wins: the expiry is suppressed
    always_comb expire = run && tick && (count == LAST) && !reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= RST_VAL;
        end else if (reload || expire) begin
            count <= load_val;
        end else if (run && tick) begin
            count <= count - LAST;
        end
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic expire,
    input  logic to_flag,
    input  logic no_reboot,
    output logic set_to,
    output logic set_sec,
    output logic rst_req
);
    wd_state_e state_q, state_d;
    logic      fire_go;

    always_comb fire_go = expire && to_flag && !no_reboot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HALT: begin
                if (!halt) state_d = fire_go ? S_FIRE : S_RUN;
            end
            S_RUN: begin
                if (fire_go)   state_d = S_FIRE;
                else if (halt) state_d = S_HALT;
            end
            S_FIRE: begin
                state_d = halt ? S_HALT : S_RUN;
            end
            default: state_d = S_HALT;
        endcase
    end

    always_comb begin
        set_to  = expire && !to_flag;
        set_sec = expire && to_flag;
        rst_req = (state_q == S_FIRE);
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned   DW     = 16,
    parameter int unsigned   TW     = 10,
    parameter int unsigned   TMIN   = 2,
    parameter int unsigned   TO_DEF = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              nr_lock,
    input  logic              set_to,
    input  logic              set_sec,
    output logic [DW-1:0]     rdata,
    output logic              halt,
    output logic [TW-1:0]     toval,
    output logic              reload,
    output logic              to_flag,
    output logic              sec_flag,
    output logic              smi_en,
    output logic              no_reboot
);
    localparam int unsigned TMAX = (1 << TW) - 1;

    logic keep_q;
    logic boot_flag;
    logic wr_ctrl, wr_tov, wr_sts1, wr_sts2, wr_ien, wr_gate;

    function automatic logic [TW-1:0] clamp_tov(input logic [DW-1:0] v);
        if (v < DW'(TMIN))      return TW'(TMIN);
        else if (v > DW'(TMAX)) return TW'(TMAX);
        else                    return v[TW-1:0];
    endfunction

    always_comb begin
        wr_ctrl = wr && (addr == A_CTRL);
        wr_tov  = wr && (addr == A_TOVAL);
        wr_sts1 = wr && (addr == A_STS1);
        wr_sts2 = wr && (addr == A_STS2);
        wr_ien  = wr && (addr == A_IRQEN);
        wr_gate = wr && (addr == A_GATE);
        reload  = wr && (addr == A_KICK) && (|wdata[4:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt      <= 1'b1;
            keep_q    <= 1'b0;
            toval     <= TW'(TO_DEF);
            to_flag   <= 1'b0;
            smi_en    <= 1'b0;
            no_reboot <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                halt   <= wdata[HALT_BIT];
                keep_q <= wdata[KEEP_BIT];
            end
            if (wr_tov) toval <= clamp_tov(wdata);
            if (set_to)                    to_flag <= 1'b1;
            else if (wr_sts1 && wdata[0])  to_flag <= 1'b0;
            if (wr_ien) smi_en <= wdata[0];
            if (nr_lock)      no_reboot <= 1'b1;
            else if (wr_gate) no_reboot <= wdata[0];
        end
    end

    // power-on domain: survives the system reset this block requests
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sec_flag  <= 1'b0;
            boot_flag <= 1'b1;
        end else begin
            if (set_sec)                  sec_flag <= 1'b1;
            else if (wr_sts2 && wdata[0]) sec_flag <= 1'b0;
            if (wr_sts2 && wdata[1] && !wdata[0]) boot_flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[HALT_BIT] = halt;
                rdata[KEEP_BIT] = keep_q;
            end
            A_TOVAL: rdata[TW-1:0] = toval;
            A_STS1:  rdata[0] = to_flag;
            A_STS2: begin
                rdata[0] = sec_flag;
                rdata[1] = boot_flag;
            end
            A_IRQEN: rdata[0] = smi_en;
            A_GATE:  rdata[0] = no_reboot;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned TW     = 10,
    parameter int unsigned TMIN   = 2,
    parameter int unsigned TO_DEF = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              nr_lock,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    output logic              sys_rst_req
);
    logic          rst_core_n;
    logic          halt, reload, to_flag, sec_flag, smi_en, no_reboot;
    logic          expire, set_to, set_sec;
    logic [TW-1:0] toval, count;

    always_comb rst_core_n = rst_n & por_n;

    wdog_regs #(.DW(DW), .TW(TW), .TMIN(TMIN), .TO_DEF(TO_DEF)) u_regs (
        .clk(clk), .rst_n(rst_core_n), .por_n(por_n),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .nr_lock(nr_lock), .set_to(set_to), .set_sec(set_sec),
        .rdata(reg_rdata), .halt(halt), .toval(toval), .reload(reload),
        .to_flag(to_flag), .sec_flag(sec_flag), .smi_en(smi_en),
        .no_reboot(no_reboot)
    );

    wdog_counter #(.TW(TW), .RST_VAL(TW'(TO_DEF))) u_cnt (
        .clk(clk), .rst_n(rst_core_n), .run(!halt), .tick(tick_en),
        .reload(reload), .load_val(toval), .count(count), .expire(expire)
    );

    wdog_fsm u_fsm (
        .clk(clk), .rst_n(rst_core_n), .halt(halt), .expire(expire),
        .to_flag(to_flag), .no_reboot(no_reboot),
        .set_to(set_to), .set_sec(set_sec), .rst_req(sys_rst_req)
    );

    always_comb irq = to_flag && smi_en;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int unsigned TW   = 10,
    parameter int unsigned TMIN = 2
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wbit0,
    input logic              sys_rst_req,
    input logic              nr_lock,
    input logic              no_reboot,
    input logic              halt,
    input logic              reload,
    input logic [TW-1:0]     count,
    input logic [TW-1:0]     toval,
    input logic              sec_flag
);
    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    // R10
    gate_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> !$past(no_reboot));

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nr_lock |=> no_reboot);

    // R4
    toval_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        toval >= TW'(TMIN));

    // R2
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(count));

    // R11
    sec_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sec_flag && !(reg_wr && reg_addr == A_STS2 && wbit0)) |=> sec_flag);
endmodule

bind wdog_ctrl wdog_chk #(.TW(TW), .TMIN(TMIN)) u_chk (
    .clk(clk), .por_n(por_n), .rst_n(rst_core_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .wbit0(reg_wdata[0]),
    .sys_rst_req(sys_rst_req), .nr_lock(nr_lock), .no_reboot(no_reboot),
    .halt(halt), .reload(reload), .count(count), .toval(toval),
    .sec_flag(sec_flag)
);

// File: tb/test_wdog_ctrl.sv
module test_wdog_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        por_n, rst_n, tick_en, nr_lock, reg_wr;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        irq, sys_rst_req;
    int          nchk = 0;
    int          nerr = 0;
    logic        finished = 1'b0;

    always #2 clk = ~clk;

    wdog_ctrl i_wdog_ctrl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
        .nr_lock(nr_lock), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sys_rst_req(sys_rst_req)
    );

    function automatic logic [15:0] exp_tov(input logic [15:0] v);
        if (v < 16'd2)         return 16'd2;
        else if (v > 16'd1023) return 16'd1023;
        else                   return v;
    endfunction

    function automatic logic [15:0] exp_ctrl(input logic [15:0] v);
        return v & 16'h0A00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] d, v;
        int n;
        logic seen;
        void'($urandom(32'd4242));
        por_n = 0; rst_n = 0; tick_en = 0; nr_lock = 0;
        reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        idle(3);
        por_n = 1; rst_n = 1;
        idle(1);

        // R1 reset state
        rd(3'd0, d); chk("R1 ctrl", d, 16'h0800);
        rd(3'd1, d); chk("R1 timeout", d, 16'd16);
        rd(3'd3, d); chk("R1 status1", d, 16'h0);
        rd(3'd4, d); chk("R1 status2", d, 16'h2);
        rd(3'd5, d); chk("R1 irq enable", d, 16'h0);
        rd(3'd6, d); chk("R1 gate", d, 16'h0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 rst_req", sys_rst_req, 1'b0);

        // R4 directed and random clamp, R3 random control writes
        foreach (d[i]) begin end
        for (int k = 0; k < 30; k++) begin
            if (k == 0)      v = 16'd0;
            else if (k == 1) v = 16'd1;
            else if (k == 2) v = 16'd2;
            else if (k == 3) v = 16'd1023;
            else if (k == 4) v = 16'd1024;
            else if (k == 5) v = 16'hFFFF;
            else             v = 16'($urandom_range(0, 2047));
            wr(3'd1, v);
            rd(3'd1, d); chk("R4 timeout clamp", d, exp_tov(v));
        end
        for (int k = 0; k < 16; k++) begin
            v = 16'($urandom);
            wr(3'd0, v);
            rd(3'd0, d); chk("R3 control readback", d, exp_ctrl(v));
        end
        wr(3'd0, 16'h0800);

        // R2 halt and tick gating
        wr(3'd5, 16'h1);
        wr(3'd1, 16'd5);
        tick_en = 1;
        wr(3'd2, 16'h1);
        idle(30);
        rd(3'd3, d); chk("R2 halted no expiry", d, 16'h0);
        tick_en = 0;
        wr(3'd0, 16'h0000);
        idle(30);
        rd(3'd3, d); chk("R2 no tick no expiry", d, 16'h0);
        tick_en = 1;
        wait_irq(n);
        chk("R7 first expiry ticks", n, 5);
        rd(3'd3, d); chk("R7 status1 set", d, 16'h1);

        // R9 second expiry
        n = 0;
        while (!sys_rst_req && n < 500) begin @(negedge clk); n++; end
        chk("R9 second expiry ticks", n, 5);
        @(negedge clk);
        chk("R9 pulse one cycle", sys_rst_req, 1'b0);
        rd(3'd4, d); chk("R9 status2", d, 16'h3);

        // R11 persistence across system reset
        rst_n = 0; idle(2); rst_n = 1; idle(1);
        rd(3'd4, d); chk("R11 status2 kept", d, 16'h3);
        rd(3'd3, d); chk("R11 status1 reset", d, 16'h0);
        rd(3'd0, d); chk("R11 ctrl reset", d, 16'h0800);

        // R12 two separate clears
        wr(3'd4, 16'h3);
        rd(3'd4, d); chk("R12 combined clear", d, 16'h2);
        wr(3'd4, 16'h2);
        rd(3'd4, d); chk("R12 boot clear", d, 16'h0);

        // R7 enable gating, R8 write-one-to-clear
        wr(3'd1, 16'd4);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h1);
        n = 0;
        d = 16'h0;
        while (d[0] == 1'b0 && n < 500) begin @(negedge clk); rd(3'd3, d); n++; end
        chk("R7 irq disabled", irq, 1'b0);
        wr(3'd3, 16'h0);
        rd(3'd3, d); chk("R8 write zero keeps", d, 16'h1);
        wr(3'd3, 16'h1);
        rd(3'd3, d); chk("R8 write one clears", d, 16'h0);
        wr(3'd0, 16'h0800);

        // R10 no-reboot gate and lock
        wr(3'd3, 16'h1);
        wr(3'd6, 16'h1);
        wr(3'd2, 16'h1);
        wr(3'd0, 16'h0000);
        seen = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); seen |= sys_rst_req; end
        chk("R10 gate blocks reset", seen, 1'b0);
        rd(3'd4, d); chk("R10 second flag still set", d[0], 1'b1);
        wr(3'd0, 16'h0800);
        wr(3'd3, 16'h1);
        wr(3'd4, 16'h1);
        nr_lock = 1;
        wr(3'd6, 16'h0);
        rd(3'd6, d); chk("R10 lock holds gate", d, 16'h1);
        nr_lock = 0;
        wr(3'd6, 16'h0);
        rd(3'd6, d); chk("R10 gate clears unlocked", d, 16'h0);

        // R6 timeout change waits for reload, R5 zero low bits ignored
        wr(3'd5, 16'h1);
        wr(3'd1, 16'd6);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h1);
        wr(3'd1, 16'd20);
        wait_irq(n);
        chk("R6 old value in use", n + 1, 6);
        wr(3'd3, 16'h1);
        wr(3'd2, 16'h1);
        idle(2);
        wr(3'd2, 16'h00E0);
        wait_irq(n);
        chk("R5 ignored kick and R6 new value", n + 3, 20);
        wr(3'd3, 16'h1);

        // R13 kick in the expiry cycle wins
        wr(3'd1, 16'd5);
        wr(3'd2, 16'h1);
        idle(4);
        wr(3'd2, 16'h1);
        rd(3'd3, d); chk("R13 expiry suppressed", d, 16'h0);
        wait_irq(n);
        chk("R13 new period", n, 5);
        wr(3'd3, 16'h1);

        // R5 regular kicks keep it quiet
        for (int k = 0; k < 10; k++) begin wr(3'd2, 16'h10); idle(2); end
        rd(3'd3, d); chk("R5 kicks prevent expiry", d, 16'h0);
        wr(3'd0, 16'h0800);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule